// File: doc/BRIEF.md
# ALU with Operation Selector and Branch-Condition Logic

This block is the execute-stage arithmetic unit of a single-cycle processor. It takes the 6-bit opcode and the 6-bit function code of the current instruction together with two 32-bit operands, and it returns a 32-bit result, a flag that marks an all-zero result, and a branch-condition flag for the next-PC logic. The operand multiplexing happens in the surrounding datapath. For immediate forms, the second operand arrives already extended.

An internal selector sorts each instruction by class. Register-register instructions take their operation from the function code. Immediate ALU instructions take their operation from the opcode. Loads and stores always add, which forms base plus offset. Conditional branches feed the branch-condition logic instead of producing an arithmetic result. Equality branches reuse the subtractor and test its output for zero. The two sign-test branches look only at the first operand. The whole block is combinational: every output follows its inputs in the same cycle. There is no state machine and no register.

Top module: `alu_bcond_unit`

## Requirements
- R1: With opcode 000000, the function code selects the result: 100000 gives A+B, 100010 gives A-B, 100100 gives A AND B, 100101 gives A OR B, 100110 gives A XOR B, 100111 gives NOT(A OR B), and 101010 gives 1 when A is less than B as signed values and 0 otherwise.
- R2: With opcode 000000 and any function code not listed in R1, the result is 0.
- R3: The immediate opcodes select the operation whatever the function code is: 001000 gives A+B, 001010 gives the signed less-than of R1, 001100 gives AND, 001101 gives OR, and 001110 gives XOR.
- R4: Opcodes 100011 (load word) and 101011 (store word) give A+B whatever the function code is.
- R5: Opcode 000100 (branch if equal) gives a result of A-B and sets bcond exactly when A equals B.
- R6: Opcode 000101 (branch if not equal) gives a result of A-B and sets bcond exactly when A differs from B.
- R7: Opcode 000110 (branch if less or equal zero) sets bcond when A, read as signed, is at most 0. B has no effect, and the result is 0.
- R8: Opcode 000111 (branch if greater than zero) sets bcond when A, read as signed, is above 0. B has no effect, and the result is 0.
- R9: The zero flag is 1 exactly when all 32 result bits are 0.
- R10: bcond is 0 for every opcode other than the four branch opcodes.
- R11: Any opcode not named in R1 to R8 gives a result of 0.
- R12: Addition and subtraction wrap modulo 2^32 and raise no error on signed overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 6 | Instruction opcode field |
| funct_i | input | 6 | Function code field, used only with opcode 000000 |
| src_a_i | input | 32 | First operand (register read port 1) |
| src_b_i | input | 32 | Second operand (register or extended immediate) |
| result_o | output | 32 | ALU result |
| zero_o | output | 1 | High when result_o is all zeros |
| bcond_o | output | 1 | Branch condition for the next-PC logic |

## Verification
The block holds no state, so any fault in its decoded operation or branch kind shows on result_o, zero_o or bcond_o in the same cycle as the instruction that exercises it. A wrong class decode shows up in three ways: a function code that leaks into immediate or memory instructions, a nonzero result on an unused opcode, or a bcond raised outside a branch. The bench provokes each of these with deliberately conflicting function codes and operand values. The sign-test branches are probed at 0, at -1, at +1 and at the most negative value, with B varied to show it has no effect.

// File: rtl/alu_bcond_pkg.sv
package alu_bcond_pkg;

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_BNE   = 6'b000101;
    localparam logic [5:0] OPC_BLEZ  = 6'b000110;
    localparam logic [5:0] OPC_BGTZ  = 6'b000111;
    localparam logic [5:0] OPC_ADDI  = 6'b001000;
    localparam logic [5:0] OPC_SLTI  = 6'b001010;
    localparam logic [5:0] OPC_ANDI  = 6'b001100;
    localparam logic [5:0] OPC_ORI   = 6'b001101;
    localparam logic [5:0] OPC_XORI  = 6'b001110;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_XOR = 6'b100110;
    localparam logic [5:0] FN_NOR = 6'b100111;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_NONE, ALU_ADD, ALU_SUB, ALU_AND,
        ALU_OR,   ALU_XOR, ALU_NOR, ALU_SLT
    } alu_op_e;

    typedef enum logic [2:0] {
        BR_NONE, BR_EQ, BR_NE, BR_LEZ, BR_GTZ
    } br_kind_e;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_bcond_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output alu_op_e    op_o,
    output br_kind_e   br_o
);

    alu_op_e reg_op;

    // Register-register class: function code picks the operation.
    always_comb begin
        case (funct_i)
            FN_ADD:  reg_op = ALU_ADD;
            FN_SUB:  reg_op = ALU_SUB;
            FN_AND:  reg_op = ALU_AND;
            FN_OR:   reg_op = ALU_OR;
            FN_XOR:  reg_op = ALU_XOR;
            FN_NOR:  reg_op = ALU_NOR;
            FN_SLT:  reg_op = ALU_SLT;
            default: reg_op = ALU_NONE;
        endcase
    end

    // Instruction class selects the source of the operation.
    always_comb begin
        op_o = ALU_NONE;
        br_o = BR_NONE;
        case (opcode_i)
            OPC_REG:   op_o = reg_op;
            OPC_ADDI:  op_o = ALU_ADD;
            OPC_SLTI:  op_o = ALU_SLT;
            OPC_ANDI:  op_o = ALU_AND;
            OPC_ORI:   op_o = ALU_OR;
            OPC_XORI:  op_o = ALU_XOR;
            OPC_LOAD,
            OPC_STORE: op_o = ALU_ADD;
            OPC_BEQ:   begin op_o = ALU_SUB; br_o = BR_EQ;  end
            OPC_BNE:   begin op_o = ALU_SUB; br_o = BR_NE;  end
            OPC_BLEZ:  br_o = BR_LEZ;
            OPC_BGTZ:  br_o = BR_GTZ;
            default:   begin op_o = ALU_NONE; br_o = BR_NONE; end
        endcase
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_bcond_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] y_o
);

    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] diff;
    logic              lt_signed;

    assign sum       = a_i + b_i;
    assign diff      = a_i - b_i;
    assign lt_signed = $signed(a_i) < $signed(b_i);

    always_comb begin
        case (op_i)
            ALU_ADD: y_o = sum;
            ALU_SUB: y_o = diff;
            ALU_AND: y_o = a_i & b_i;
            ALU_OR:  y_o = a_i | b_i;
            ALU_XOR: y_o = a_i ^ b_i;
            ALU_NOR: y_o = ~(a_i | b_i);
            ALU_SLT: y_o = {{(DATA_W-1){1'b0}}, lt_signed};
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/branch_cond.sv
module branch_cond
    import alu_bcond_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  br_kind_e          kind_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic              diff_zero_i,
    output logic              bcond_o
);

    logic a_is_zero;
    logic a_is_neg;

    assign a_is_zero = (a_i == '0);
    assign a_is_neg  = a_i[DATA_W-1];

    always_comb begin
        case (kind_i)
            BR_EQ:   bcond_o = diff_zero_i;
            BR_NE:   bcond_o = ~diff_zero_i;
            BR_LEZ:  bcond_o = a_is_neg | a_is_zero;
            BR_GTZ:  bcond_o = ~a_is_neg & ~a_is_zero;
            default: bcond_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_bcond_unit.sv
module alu_bcond_unit
    import alu_bcond_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [5:0]        opcode_i,
    input  logic [5:0]        funct_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    output logic [DATA_W-1:0] result_o,
    output logic              zero_o,
    output logic              bcond_o
);

    alu_op_e  op_sel;
    br_kind_e br_sel;

    alu_op_decode dec_i (
        .opcode_i (opcode_i),
        .funct_i  (funct_i),
        .op_o     (op_sel),
        .br_o     (br_sel)
    );

    alu_core #(.DATA_W(DATA_W)) core_i (
        .op_i (op_sel),
        .a_i  (src_a_i),
        .b_i  (src_b_i),
        .y_o  (result_o)
    );

    assign zero_o = ~|result_o;

    branch_cond #(.DATA_W(DATA_W)) brc_i (
        .kind_i      (br_sel),
        .a_i         (src_a_i),
        .diff_zero_i (zero_o),
        .bcond_o     (bcond_o)
    );

endmodule

// File: rtl/alu_bcond_chk.sv
module alu_bcond_chk
    import alu_bcond_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic [5:0]        opcode_i,
    input logic [5:0]        funct_i,
    input logic [DATA_W-1:0] src_a_i,
    input logic [DATA_W-1:0] src_b_i,
    input logic [DATA_W-1:0] result_o,
    input logic              zero_o,
    input logic              bcond_o
);

    logic known;
    logic is_branch;

    assign known = !$isunknown({opcode_i, funct_i, src_a_i, src_b_i});
    assign is_branch = (opcode_i == OPC_BEQ) || (opcode_i == OPC_BNE) ||
                       (opcode_i == OPC_BLEZ) || (opcode_i == OPC_BGTZ);

    always_comb begin
        if (known) begin
            p_zero_flag_r9: assert (zero_o == (result_o == '0))
                else $error("zero flag disagrees with result");
            p_no_bcond_r10: assert (is_branch || !bcond_o)
                else $error("bcond raised outside a branch");
            if (opcode_i == OPC_BEQ) begin
                p_beq_equal_r5: assert (bcond_o == (src_a_i == src_b_i))
                    else $error("BEQ condition wrong");
            end
            if (opcode_i == OPC_BNE) begin
                p_bne_differ_r6: assert (bcond_o == (src_a_i != src_b_i))
                    else $error("BNE condition wrong");
            end
            if (opcode_i == OPC_BLEZ) begin
                p_blez_sign_r7: assert (bcond_o == ($signed(src_a_i) <= 0) && result_o == '0)
                    else $error("BLEZ condition wrong");
            end
            if (opcode_i == OPC_BGTZ) begin
                p_bgtz_sign_r8: assert (bcond_o == ($signed(src_a_i) > 0) && result_o == '0)
                    else $error("BGTZ condition wrong");
            end
            if (opcode_i == OPC_LOAD || opcode_i == OPC_STORE) begin
                p_mem_add_r4: assert (result_o == src_a_i + src_b_i)
                    else $error("memory address sum wrong");
            end
        end
    end

endmodule

bind alu_bcond_unit alu_bcond_chk #(.DATA_W(DATA_W)) chk_i (
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .result_o (result_o),
    .zero_o   (zero_o),
    .bcond_o  (bcond_o)
);

// File: tb/alu_bcond_unit_tb_top.sv
module alu_bcond_unit_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   opcode;
    logic [5:0]   funct;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] result;
    logic         zero;
    logic         bcond;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [W-1:0] res;
        logic         z;
        logic         bc;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    alu_bcond_unit #(.DATA_W(W)) dut_i (
        .opcode_i (opcode),
        .funct_i  (funct),
        .src_a_i  (a),
        .src_b_i  (b),
        .result_o (result),
        .zero_o   (zero),
        .bcond_o  (bcond)
    );

    // Driver: one instruction per cycle, expected outcome queued alongside.
    task automatic drive(input string tag, input logic [5:0] opc, input logic [5:0] fn,
                         input logic [W-1:0] va, input logic [W-1:0] vb,
                         input logic [W-1:0] eres, input logic ebc);
        exp_t e;
        @(posedge clk);
        e.res = eres;
        e.z   = (eres == '0);
        e.bc  = ebc;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        opcode = opc;
        funct  = fn;
        a      = va;
        b      = vb;
    endtask

    // Monitor: compare at the falling edge, half a cycle after the drive.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (result !== e.res || zero !== e.z || bcond !== e.bc) begin
                n_fail++;
                $display("FAIL %s: got res=%h zero=%b bcond=%b, expected res=%h zero=%b bcond=%b",
                         t, result, zero, bcond, e.res, e.z, e.bc);
            end
        end
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        opcode = '0; funct = '0; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: all-zero inputs, unlisted funct 000000 -> 0 (R2).
        drive("R2 reset", 6'b000000, 6'b000000, 32'h0, 32'h0, 32'h0, 1'b0);

        // R1 function codes
        drive("R1 add", 6'b000000, 6'b100000, 32'h0000_1234, 32'h0000_0F0F, 32'h0000_2143, 1'b0);
        drive("R1 sub", 6'b000000, 6'b100010, 32'h0000_0010, 32'h0000_0003, 32'h0000_000D, 1'b0);
        drive("R1 and", 6'b000000, 6'b100100, 32'hF0F0_FF00, 32'h3C3C_0FF0, 32'h3030_0F00, 1'b0);
        drive("R1 or",  6'b000000, 6'b100101, 32'hF0F0_0000, 32'h0F00_00FF, 32'hFFF0_00FF, 1'b0);
        drive("R1 xor", 6'b000000, 6'b100110, 32'hAAAA_5555, 32'hFFFF_0000, 32'h5555_5555, 1'b0);
        drive("R1 nor", 6'b000000, 6'b100111, 32'hF000_000F, 32'h0F00_00F0, 32'h00FF_FF00, 1'b0);
        drive("R1 slt neg<pos", 6'b000000, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h1, 1'b0);
        drive("R1 slt pos<neg", 6'b000000, 6'b101010, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0, 1'b0);

        // R2 unlisted funct
        drive("R2 funct 000001", 6'b000000, 6'b000001, 32'h1234_5678, 32'h1, 32'h0, 1'b0);
        drive("R2 funct 111111", 6'b000000, 6'b111111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b0);

        // R3 immediate class ignores funct (conflicting funct codes given)
        drive("R3 addi", 6'b001000, 6'b100010, 32'h0000_0100, 32'hFFFF_FFFF, 32'h0000_00FF, 1'b0);
        drive("R3 slti", 6'b001010, 6'b100000, 32'h8000_0000, 32'h0000_0000, 32'h1, 1'b0);
        drive("R3 andi", 6'b001100, 6'b100101, 32'h1234_5678, 32'h0000_FFFF, 32'h0000_5678, 1'b0);
        drive("R3 ori",  6'b001101, 6'b100100, 32'h1234_0000, 32'h0000_00AB, 32'h1234_00AB, 1'b0);
        drive("R3 xori", 6'b001110, 6'b100111, 32'h0000_00FF, 32'h0000_0F0F, 32'h0000_0FF0, 1'b0);

        // R4 memory address add despite sub/and funct
        drive("R4 load",  6'b100011, 6'b100010, 32'h1000_0000, 32'hFFFF_FFFC, 32'h0FFF_FFFC, 1'b0);
        drive("R4 store", 6'b101011, 6'b100100, 32'h0000_2000, 32'h0000_0010, 32'h0000_2010, 1'b0);

        // R5 / R6 equality branches
        drive("R5 beq equal",   6'b000100, 6'b000000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0, 1'b1);
        drive("R5 beq unequal", 6'b000100, 6'b000000, 32'h0000_0005, 32'h0000_0003, 32'h2, 1'b0);
        drive("R6 bne unequal", 6'b000101, 6'b000000, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 1'b1);
        drive("R6 bne equal",   6'b000101, 6'b000000, 32'h0000_0042, 32'h0000_0042, 32'h0, 1'b0);

        // R7 / R8 sign tests, B varied and must not matter
        drive("R7 blez zero", 6'b000110, 6'b000000, 32'h0, 32'h0000_0007, 32'h0, 1'b1);
        drive("R7 blez neg",  6'b000110, 6'b100000, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1);
        drive("R7 blez pos",  6'b000110, 6'b000000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0, 1'b0);
        drive("R7 blez min",  6'b000110, 6'b000000, 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b1);
        drive("R8 bgtz pos",  6'b000111, 6'b000000, 32'h0000_0001, 32'h0000_0001, 32'h0, 1'b1);
        drive("R8 bgtz zero", 6'b000111, 6'b000000, 32'h0, 32'hFFFF_FFFF, 32'h0, 1'b0);
        drive("R8 bgtz min",  6'b000111, 6'b000000, 32'h8000_0000, 32'h0, 32'h0, 1'b0);
        drive("R8 bgtz max",  6'b000111, 6'b000000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0, 1'b1);

        // R9 zero flag from arithmetic
        drive("R9 sub equal", 6'b000000, 6'b100010, 32'h0BAD_F00D, 32'h0BAD_F00D, 32'h0, 1'b0);
        drive("R9 add cancel", 6'b000000, 6'b100000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0, 1'b0);

        // R10 equal operands on non-branch: bcond stays low
        drive("R10 and equal", 6'b000000, 6'b100100, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_FFFF, 1'b0);

        // R11 unused opcodes
        drive("R11 opc 000010", 6'b000010, 6'b100000, 32'h1111_1111, 32'h2222_2222, 32'h0, 1'b0);
        drive("R11 opc 111111", 6'b111111, 6'b100000, 32'h0, 32'h0, 32'h0, 1'b0);
        drive("R11 opc 001001", 6'b001001, 6'b100101, 32'h5, 32'h6, 32'h0, 1'b0);

        // R12 wrap-around without trapping
        drive("R12 add overflow", 6'b000000, 6'b100000, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0);
        drive("R12 sub underflow", 6'b000000, 6'b100010, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0);
        drive("R12 addi wrap", 6'b001000, 6'b000000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule